// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table Controller

This block keeps, for one function, a table of interrupt vectors and a bit array of pending vectors, and turns device interrupt requests into message writes. Each vector owns a 64-bit message address, a 32-bit message data word and a per-vector mask bit. Software reaches the table and the pending array through a simple 32-bit register port. The register port is a dword port: a wider bus access is split into 32-bit operations before it reaches this block. Two capability inputs, function enable and function mask-all, come from configuration logic outside the block.

A device request for a vector that software has declared in use produces a message when the vector's effective mask is clear and the output is free. When the vector is masked, or the output is still busy, the request is held as a pending bit instead. A single drain engine sends every pending vector that is currently allowed to send, lowest index first. The effective mask can be cleared by the vector's own bit, by mask-all or by enable. In each case the held message goes out with no further request from the device.

Top module: `vecmsg_ctrl`

## Requirements
- R1: The table occupies dwords 4v..4v+3 for vector v, selected by reg_sel=0. The dword at 4v reads the address low word, 4v+1 the address high word, 4v+2 the data word, and 4v+3 the control word, whose bit 0 is the vector mask (other bits read 0). Writes take effect at the clock edge and reads are combinational.
- R2: After reset every pending bit is 0, every table address and data word is 0, every vector mask bit is 1, all use counts are 0 and msg_valid is 0.
- R3: The pending array is selected by reg_sel=1. Vector v is bit v%32 of dword v/32, which is the same as bit v%8 of byte v/8 in little-endian order. It is sized to a multiple of 64 bits, unused bits and dwords read 0, and writes to it change nothing.
- R4: A vector is effectively masked when fn_enable is 0, or fn_mask_all is 1, or its own mask bit is 1. A request for a used, effectively masked vector sets its pending bit and sends no message.
- R5: A request for a used, unmasked vector, made while the output is free and nothing else is eligible, raises msg_valid at the next edge. msg_addr is then {high word, low word}, msg_data is the data word and msg_vec is the vector, and no pending bit is left set.
- R6: When a pending vector's effective mask clears, from any of the three sources, its pending bit clears and its message is sent. Several eligible pending vectors are sent lowest index first, one per accepted transfer.
- R7: While msg_valid=1 and msg_ready=0, msg_addr, msg_data and msg_vec stay stable. A request arriving then sets the vector's pending bit and is delivered later.
- R8: A request for a vector whose use count is 0 is dropped, leaving no pending bit and sending no message. Decrementing a count from 1 to 0 clears that vector's pending bit. A decrement at 0 is ignored, and an increment saturates.
- R9: A message transfers on a cycle with msg_valid=1 and msg_ready=1. The next message may load on that same edge, so back-to-back messages are possible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = vector table, 1 = pending array |
| reg_addr | input | VIW+2 | Dword index within the selected space |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| fn_enable | input | 1 | Function interrupt enable |
| fn_mask_all | input | 1 | Function-wide mask |
| use_inc | input | 1 | Declare one more use of use_vec |
| use_dec | input | 1 | Release one use of use_vec |
| use_vec | input | VIW | Vector for use counting |
| req_valid | input | 1 | Device interrupt request strobe |
| req_vec | input | VIW | Requested vector |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted when high with msg_valid |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| msg_vec | output | VIW | Vector the message belongs to |

## Verification
A pending bit that is lost or stuck shows up in two places. A pending-array read in the cycle after the request shows it, and so does the absence of a message, or an extra one, at the edge after the mask clears. A wrong picker order is seen within the drain burst itself, since consecutive msg_vec values must count upward. A corrupted use count shows as a dropped or phantom message at the very next request for that vector. A table word written to the wrong place shows on readback, and again in msg_addr or msg_data of that vector's next message.

// File: rtl/vm_pkg.sv
package vm_pkg;

  // Vector index width, never below one bit.
  function automatic int f_viw(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Pending array size in dwords, rounded up to whole 64-bit units.
  function automatic int f_pba_dw(input int n);
    return ((n + 63) / 64) * 2;
  endfunction

  // Effective mask of one vector.
  function automatic logic f_masked(input logic en, input logic mall, input logic vmask);
    return !en || mall || vmask;
  endfunction

  typedef struct packed {
    logic [31:0] hi;
    logic [31:0] lo;
    logic [31:0] dat;
  } vm_entry_t;

endpackage

// File: rtl/vm_table.sv
module vm_table import vm_pkg::*; #(
  parameter int NVEC = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [f_viw(NVEC)+1:0]   addr,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  input  logic [f_viw(NVEC)-1:0]   ld_vec,
  output vm_entry_t                ld_ent,
  output logic [NVEC-1:0]          vmask
);
  localparam int VIW = f_viw(NVEC);
  localparam logic [VIW:0] NV_L = NVEC[VIW:0];

  vm_entry_t tbl [NVEC];

  logic [VIW-1:0] vi;
  logic [1:0]     wsel;
  logic           vi_ok;

  assign vi    = addr[VIW+1:2];
  assign wsel  = addr[1:0];
  assign vi_ok = ({1'b0, vi} < NV_L);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < NVEC; v++) tbl[v] <= '0;
      vmask <= '1;
    end else if (wr_en && vi_ok) begin
      case (wsel)
        2'd0:    tbl[vi].lo  <= wdata;
        2'd1:    tbl[vi].hi  <= wdata;
        2'd2:    tbl[vi].dat <= wdata;
        default: vmask[vi]   <= wdata[0];
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (vi_ok) begin
      case (wsel)
        2'd0:    rdata = tbl[vi].lo;
        2'd1:    rdata = tbl[vi].hi;
        2'd2:    rdata = tbl[vi].dat;
        default: rdata = {31'd0, vmask[vi]};
      endcase
    end
  end

  assign ld_ent = tbl[ld_vec];

endmodule

// File: rtl/vm_use_cnt.sv
module vm_use_cnt import vm_pkg::*; #(
  parameter int NVEC = 8,
  parameter int UCW  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inc,
  input  logic                   dec,
  input  logic [f_viw(NVEC)-1:0] vec,
  output logic [NVEC-1:0]        used,
  output logic                   zero_fire
);
  localparam int VIW = f_viw(NVEC);
  localparam logic [UCW-1:0] CMAX = '1;
  localparam logic [VIW:0] NV_L = NVEC[VIW:0];

  logic [UCW-1:0] cnt [NVEC];
  logic           up, dn;

  assign up = inc && !dec && ({1'b0, vec} < NV_L);
  assign dn = dec && !inc && ({1'b0, vec} < NV_L);

  for (genvar v = 0; v < NVEC; v++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n) cnt[v] <= '0;
      else if (up && vec == VIW'(v) && cnt[v] != CMAX) cnt[v] <= cnt[v] + 1'b1;
      else if (dn && vec == VIW'(v) && cnt[v] != '0)   cnt[v] <= cnt[v] - 1'b1;
    end
    assign used[v] = (cnt[v] != '0);
  end

  assign zero_fire = dn && (cnt[vec] == UCW'(1));

endmodule

// File: rtl/vm_pick.sv
module vm_pick import vm_pkg::*; #(
  parameter int NVEC = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NVEC-1:0]        req,
  output logic                   any,
  output logic [f_viw(NVEC)-1:0] idx
);
  localparam int VIW = f_viw(NVEC);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = VIW'(i);
      end
    end
  end

  // R6: the chosen vector is one that asked
  p_pick_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[idx]);

endmodule

// File: rtl/vecmsg_ctrl.sv
module vecmsg_ctrl import vm_pkg::*; #(
  parameter int NVEC = 8,
  parameter int UCW  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic                   reg_sel,
  input  logic [f_viw(NVEC)+1:0] reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic                   fn_enable,
  input  logic                   fn_mask_all,
  input  logic                   use_inc,
  input  logic                   use_dec,
  input  logic [f_viw(NVEC)-1:0] use_vec,
  input  logic                   req_valid,
  input  logic [f_viw(NVEC)-1:0] req_vec,
  output logic                   msg_valid,
  input  logic                   msg_ready,
  output logic [63:0]            msg_addr,
  output logic [31:0]            msg_data,
  output logic [f_viw(NVEC)-1:0] msg_vec
);
  localparam int VIW      = f_viw(NVEC);
  localparam int RAW      = VIW + 2;
  localparam int PBA_DW   = f_pba_dw(NVEC);
  localparam int PBA_BITS = PBA_DW * 32;
  localparam logic [VIW:0] NV_L = NVEC[VIW:0];

  logic [NVEC-1:0]     vmask, used, eff_mask, elig, pend, pend_n;
  logic                zero_fire;
  logic                pick_any;
  logic [VIW-1:0]      pick_idx, load_vec;
  logic                out_free, req_ok, req_unm, drain_go, direct_go, load_go;
  logic [31:0]         tbl_rd, pba_rd;
  logic [PBA_BITS-1:0] pend_full;
  vm_entry_t           ld_ent;

  vm_table #(.NVEC(NVEC)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && !reg_sel), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(tbl_rd), .ld_vec(load_vec), .ld_ent(ld_ent),
    .vmask(vmask)
  );

  vm_use_cnt #(.NVEC(NVEC), .UCW(UCW)) u_use (
    .clk(clk), .rst_n(rst_n), .inc(use_inc), .dec(use_dec), .vec(use_vec),
    .used(used), .zero_fire(zero_fire)
  );

  for (genvar v = 0; v < NVEC; v++) begin : g_mask
    assign eff_mask[v] = f_masked(fn_enable, fn_mask_all, vmask[v]);
  end

  assign elig = pend & ~eff_mask & used;

  vm_pick #(.NVEC(NVEC)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(elig), .any(pick_any), .idx(pick_idx)
  );

  // Delivery decisions
  assign out_free  = !msg_valid || msg_ready;
  assign req_ok    = req_valid && ({1'b0, req_vec} < NV_L) && used[req_vec];
  assign req_unm   = req_ok && !eff_mask[req_vec];
  assign drain_go  = out_free && pick_any;
  assign direct_go = out_free && !pick_any && req_unm;
  assign load_go   = drain_go || direct_go;
  assign load_vec  = drain_go ? pick_idx : req_vec;

  always_comb begin
    pend_n = pend;
    if (drain_go)            pend_n[pick_idx] = 1'b0;
    if (req_ok && !direct_go) pend_n[req_vec] = 1'b1;
    if (zero_fire)           pend_n[use_vec]  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
      msg_vec   <= '0;
    end else if (load_go) begin
      msg_valid <= 1'b1;
      msg_addr  <= {ld_ent.hi, ld_ent.lo};
      msg_data  <= ld_ent.dat;
      msg_vec   <= load_vec;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  // Pending array read: read-only, zero beyond N
  assign pend_full = PBA_BITS'(pend);

  always_comb begin
    pba_rd = '0;
    for (int j = 0; j < PBA_DW; j++) begin
      if (reg_addr == RAW'(j)) pba_rd = pend_full[j*32 +: 32];
    end
  end

  assign reg_rdata = reg_sel ? pba_rd : tbl_rd;

  // R4: nothing leaves while effectively masked
  p_load_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |-> !eff_mask[load_vec]);

  // R8: only vectors in use produce messages
  p_load_used_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |-> used[load_vec]);

  // R7: a stalled message holds its contents
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr)
                                   && $stable(msg_data) && $stable(msg_vec)));

  // R8: releasing the last use leaves no pending bit
  p_unuse_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    zero_fire |=> !pend[$past(use_vec)]);

endmodule

// File: tb/sim_vecmsg_ctrl.sv
module sim_vecmsg_ctrl;
  localparam int NVEC = 8;
  localparam int VIW  = 3;
  localparam int RAW  = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_wr = 1'b0, reg_sel = 1'b0;
  logic [RAW-1:0]  reg_addr = '0;
  logic [31:0]     reg_wdata = '0, reg_rdata;
  logic            fn_enable = 1'b0, fn_mask_all = 1'b0;
  logic            use_inc = 1'b0, use_dec = 1'b0;
  logic [VIW-1:0]  use_vec = '0;
  logic            req_valid = 1'b0;
  logic [VIW-1:0]  req_vec = '0;
  logic            msg_valid, msg_ready = 1'b0;
  logic [63:0]     msg_addr;
  logic [31:0]     msg_data;
  logic [VIW-1:0]  msg_vec;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vecmsg_ctrl #(.NVEC(NVEC), .UCW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fn_enable(fn_enable), .fn_mask_all(fn_mask_all), .use_inc(use_inc),
    .use_dec(use_dec), .use_vec(use_vec), .req_valid(req_valid),
    .req_vec(req_vec), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data), .msg_vec(msg_vec)
  );

  function automatic logic [31:0] e_lo(int v);  return 32'h4000_0000 | (v << 4); endfunction
  function automatic logic [31:0] e_hi(int v);  return 32'h0000_00F0 + v;        endfunction
  function automatic logic [31:0] e_dat(int v); return 32'h0000_C000 + v * 3;    endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic sel, input int a, output logic [31:0] d);
    reg_sel = sel; reg_addr = RAW'(a); #1; d = reg_rdata;
  endtask

  task automatic wr(input logic sel, input int a, input logic [31:0] d);
    reg_sel = sel; reg_addr = RAW'(a); reg_wdata = d; reg_wr = 1'b1;
    tick(); reg_wr = 1'b0;
  endtask

  task automatic request(input int v);
    req_vec = VIW'(v); req_valid = 1'b1; tick(); req_valid = 1'b0;
  endtask

  task automatic use_op(input bit up, input int v);
    use_vec = VIW'(v); use_inc = up; use_dec = !up; tick();
    use_inc = 1'b0; use_dec = 1'b0;
  endtask

  task automatic check_msg(string tag, int v);
    check({tag, " valid"}, 64'(msg_valid), 64'd1);
    check({tag, " vec"},   64'(msg_vec),   64'(v));
    check({tag, " addr"},  msg_addr,       {e_hi(v), e_lo(v)});
    check({tag, " data"},  64'(msg_data),  64'(e_dat(v)));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
  endtask

  task automatic check_reset_state(string tag);
    logic [31:0] d;
    check({tag, " msg_valid"}, 64'(msg_valid), 64'd0);
    for (int v = 0; v < NVEC; v++) begin
      for (int w = 0; w < 4; w++) begin
        rd(1'b0, v * 4 + w, d);
        check({tag, " table word"}, 64'(d), (w == 3) ? 64'd1 : 64'd0);
      end
    end
    for (int k = 0; k < 4; k++) begin
      rd(1'b1, k, d);
      check({tag, " pending"}, 64'(d), 64'd0);
    end
  endtask

  initial begin
    logic [31:0] d;
    do_reset();
    check_reset_state("R2 reset");

    // R1: fill and read back the table
    for (int v = 0; v < NVEC; v++) begin
      wr(1'b0, v * 4 + 0, e_lo(v));
      wr(1'b0, v * 4 + 1, e_hi(v));
      wr(1'b0, v * 4 + 2, e_dat(v));
    end
    for (int v = 0; v < NVEC; v++) begin
      rd(1'b0, v * 4 + 0, d); check("R1 lo",   64'(d), 64'(e_lo(v)));
      rd(1'b0, v * 4 + 1, d); check("R1 hi",   64'(d), 64'(e_hi(v)));
      rd(1'b0, v * 4 + 2, d); check("R1 data", 64'(d), 64'(e_dat(v)));
      rd(1'b0, v * 4 + 3, d); check("R1 ctrl", 64'(d), 64'd1);
    end
    for (int v = 0; v < NVEC; v++) use_op(1'b1, v);
    fn_enable = 1'b1;

    // R4: request on a vector masked by its own bit
    request(3);
    check("R4 no message", 64'(msg_valid), 64'd0);
    rd(1'b1, 0, d); check("R4 pending bit3", 64'(d), 64'h8);

    // R3: pending array is read-only, upper dwords zero
    wr(1'b1, 0, 32'hFFFF_FFFF);
    rd(1'b1, 0, d); check("R3 write ignored", 64'(d), 64'h8);
    rd(1'b1, 1, d); check("R3 dword1 zero", 64'(d), 64'd0);
    rd(1'b1, 2, d); check("R3 beyond zero", 64'(d), 64'd0);

    // R6: unmask via vector bit, R7: stall holds
    wr(1'b0, 3 * 4 + 3, 32'd0);
    check("R6 not yet", 64'(msg_valid), 64'd0);
    tick();
    check_msg("R6 vec-bit unmask", 3);
    rd(1'b1, 0, d); check("R6 pending cleared", 64'(d), 64'd0);
    for (int i = 0; i < 3; i++) begin
      tick();
      check_msg("R7 stalled hold", 3);
    end
    msg_ready = 1'b1; tick();
    check("R9 transferred", 64'(msg_valid), 64'd0);
    msg_ready = 1'b0;

    // R6: mask-all release drains lowest index first
    fn_mask_all = 1'b1;
    for (int v = 0; v < NVEC; v++) wr(1'b0, v * 4 + 3, 32'd0);
    for (int v = NVEC - 1; v >= 0; v--) request(v);
    check("R4 mask-all no message", 64'(msg_valid), 64'd0);
    rd(1'b1, 0, d); check("R4 all pending", 64'(d), 64'hFF);
    msg_ready = 1'b1; fn_mask_all = 1'b0;
    tick();
    for (int i = 0; i < NVEC; i++) begin
      check_msg("R6 R9 drain order", i);
      tick();
    end
    check("R6 drain done", 64'(msg_valid), 64'd0);
    rd(1'b1, 0, d); check("R6 pending empty", 64'(d), 64'd0);

    // R4 R6: enable as the mask source
    fn_enable = 1'b0; msg_ready = 1'b0;
    request(5);
    check("R4 disabled no message", 64'(msg_valid), 64'd0);
    rd(1'b1, 0, d); check("R4 disabled pending", 64'(d), 64'h20);
    fn_enable = 1'b1; tick();
    check_msg("R6 enable release", 5);
    msg_ready = 1'b1; tick();
    check("R9 enable msg taken", 64'(msg_valid), 64'd0);

    // R5: direct delivery
    request(2);
    check_msg("R5 direct", 2);
    rd(1'b1, 0, d); check("R5 no pending", 64'(d), 64'd0);
    tick();
    check("R5 taken", 64'(msg_valid), 64'd0);

    // R7: request while output busy is queued
    msg_ready = 1'b0;
    request(1);
    check_msg("R7 first", 1);
    request(6);
    check_msg("R7 still first", 1);
    rd(1'b1, 0, d); check("R7 queued pending", 64'(d), 64'h40);
    msg_ready = 1'b1; tick();
    check_msg("R7 R9 back-to-back", 6);
    rd(1'b1, 0, d); check("R7 queue empty", 64'(d), 64'd0);
    tick();
    check("R7 done", 64'(msg_valid), 64'd0);

    // R8: use counting
    use_op(1'b0, 4);
    request(4);
    check("R8 unused no message", 64'(msg_valid), 64'd0);
    rd(1'b1, 0, d); check("R8 unused no pending", 64'(d), 64'd0);
    fn_mask_all = 1'b1;
    request(7);
    rd(1'b1, 0, d); check("R8 pending before release", 64'(d), 64'h80);
    use_op(1'b0, 7);
    rd(1'b1, 0, d); check("R8 release clears pending", 64'(d), 64'd0);
    fn_mask_all = 1'b0; tick();
    check("R8 nothing after release", 64'(msg_valid), 64'd0);
    use_op(1'b0, 4);
    use_op(1'b1, 4);
    request(4);
    check_msg("R8 count not wrapped", 4);
    tick();
    for (int i = 0; i < 17; i++) use_op(1'b1, 0);
    for (int i = 0; i < 14; i++) use_op(1'b0, 0);
    request(0);
    check_msg("R8 saturated count still used", 0);
    tick();

    // R2: reset again after activity
    do_reset();
    check_reset_state("R2 second reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule